// File: doc/BRIEF.md
# Burst-and-Hold DMA Channel

This block is one programmable DMA channel that masters a simple memory bus. Software fills a small register set with a mode, a source pointer, a destination preload, an item count preload, a burst length, a hold length and an item size, and then sets a start bit. The channel moves one item at a time: one bus read followed by one bus write. After each burst it drops its bus request for a programmed number of cycles, so that other masters can use the bus.

Two modes are supported. In memory-to-memory mode the item is 8, 16 or 32 bits wide, and both pointers advance by the item width. In peripheral-to-memory mode every access is 32 bits wide and the source pointer stays fixed. Only the low 8, 16 or 32 bits of the data carry meaning. In this mode a software trigger bit can take the place of the peripheral ready input. When the count runs out, the channel clears its start bit and raises a sticky done flag.

The bus port is a valid/ready pair. `bus_req` is the valid signal and `bus_gnt` is the ready signal. A beat completes in any cycle where both are high. While `bus_req` is high and `bus_gnt` is low, the channel holds `bus_we`, `bus_addr`, `bus_size` and `bus_wdata` steady. For a read, `bus_rdata` must be valid in the cycle where the grant is given. The channel never withdraws a request that has not been granted.

Top module: `dma_burst_hold`

## Requirements
- R1: After reset, `bus_req` and `done` are low. The channel starts no access until it is started.
- R2: A write to the control register (offset 0) with bit 8 set starts the channel when two conditions hold: the mode field in bits 2:0 is 0 or 1, and the channel is not already started. Starting loads the working destination pointer and the item count from their preload registers (offset 2 and offset 3) and clears `done`. A start with any other mode is ignored. While the channel is started, all register writes are ignored.
- R3: Before each item, the channel waits in an idle cycle until it sees ready. Ready is `periph_rdy`, or, in mode 1 only, the trigger bit 9 of the control register. Two items of the same burst are separated by exactly one cycle with `bus_req` low.
- R4: Each item is moved as a read (`bus_we`=0) at the source pointer followed by a write (`bus_we`=1) at the destination pointer. The request and its address stay stable until granted. The item count drops only on a granted write.
- R5: In mode 0, the size field in bits 5:4 of the control register selects 8, 16 or 32 bits with codes 0, 1 and 2; code 3 acts as 32 bits. `bus_size` carries that code, and both pointers advance by 1, 2 or 4 bytes per item.
- R6: In mode 1, `bus_size` is always 2 (32 bits). The source pointer never moves, and the destination pointer advances by 4 per item.
- R7: The burst length is in bits 7:0 of offset 4; a value of 0 counts as 1. The hold length H is in bits 15:8 of offset 4. After the last write of a burst that does not finish the transfer, `bus_req` stays low for H+1 cycles.
- R8: When the count reaches zero, the channel clears its start bit and sets `done`. A start with a preload count of 0 sets `done` at once and performs no access. `done` stays high until the next valid start.
- R9: The write data equals the data read for that item, with the bits above the item size forced to zero. This applies in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset (0 control, 1 source, 2 destination preload, 3 count preload, 4 burst/hold) |
| cfg_wdata | input | 32 | Register write data |
| periph_rdy | input | 1 | Ready input that lets the next item proceed |
| bus_req | output | 1 | Bus request (valid) |
| bus_gnt | input | 1 | Bus grant (ready); a beat completes when both are high |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | ADDR_W | Byte address of the beat |
| bus_size | output | 2 | Access size code: 0 = 8, 1 = 16, 2 = 32 bits |
| bus_wdata | output | 32 | Write data, low-aligned |
| bus_rdata | input | 32 | Read data, valid in the granted read cycle |
| done | output | 1 | Sticky completion flag |

## Verification
The hardest situations to reach are the ones where several timing conditions overlap. One is a grant that is withheld on the last write of a burst, followed by a hold window, with ready then low at the idle cycle that comes after. Another is a register write that arrives in the middle of a transfer. The stimulus drives the grant from a pseudo-random sequence and toggles ready in some runs, so that stalls land on reads, writes and burst boundaries alike. It also writes a different source pointer while a transfer is running. A behavioural model follows every cycle and exposes any drift in the address or the gap timing.

// File: rtl/dma_bh_pkg.sv
package dma_bh_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_HOLD} dma_st_e;

  localparam logic [2:0] MODE_M2M = 3'd0;
  localparam logic [2:0] MODE_P2M = 3'd1;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_SRC  = 3'd1;
  localparam logic [2:0] OFS_DST  = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd3;
  localparam logic [2:0] OFS_BH   = 3'd4;

  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [1:0] norm_size(input logic [1:0] sz);
    norm_size = (sz == 2'd3) ? 2'd2 : sz;
  endfunction
endpackage

// File: rtl/dma_bh_regs.sv
module dma_bh_regs
  import dma_bh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              fin,
  output logic [2:0]        mode,
  output logic [1:0]        size,
  output logic              trig,
  output logic [ADDR_W-1:0] src_cfg,
  output logic [ADDR_W-1:0] dst_pre,
  output logic [CNT_W-1:0]  cnt_pre,
  output logic [7:0]        burst,
  output logic [7:0]        hold,
  output logic              start,
  output logic              done,
  output logic              load
);
  logic wr_ok;
  assign wr_ok = cfg_we && !start;
  assign load  = wr_ok && (cfg_addr == OFS_CTRL) && cfg_wdata[8] &&
                 ((cfg_wdata[2:0] == MODE_M2M) || (cfg_wdata[2:0] == MODE_P2M));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; size <= '0; trig <= 1'b0;
      src_cfg <= '0; dst_pre <= '0; cnt_pre <= '0;
      burst <= '0; hold <= '0; start <= 1'b0; done <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (cfg_addr)
          OFS_CTRL: begin
            mode <= cfg_wdata[2:0];
            size <= cfg_wdata[5:4];
            trig <= cfg_wdata[9];
          end
          OFS_SRC: src_cfg <= cfg_wdata[ADDR_W-1:0];
          OFS_DST: dst_pre <= cfg_wdata[ADDR_W-1:0];
          OFS_CNT: cnt_pre <= cfg_wdata[CNT_W-1:0];
          OFS_BH: begin
            burst <= cfg_wdata[7:0];
            hold  <= cfg_wdata[15:8];
          end
          default: ;
        endcase
      end
      if (load) begin
        start <= 1'b1;
        done  <= 1'b0;
      end
      if (fin) begin
        start <= 1'b0;
        done  <= 1'b1;
      end
    end
  end

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> done);
  p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!start && done));
endmodule

// File: rtl/dma_bh_addr.sv
module dma_bh_addr
  import dma_bh_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [2:0]        mode,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] src_cfg,
  input  logic [ADDR_W-1:0] dst_pre,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr
);
  logic [ADDR_W-1:0] step;
  logic              p2m;

  assign p2m = (mode == MODE_P2M);

  always_comb begin
    case (norm_size(size))
      2'd0:    step = ADDR_W'(1);
      2'd1:    step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
    if (p2m) step = ADDR_W'(4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ptr <= '0;
      dst_ptr <= '0;
    end else if (load) begin
      src_ptr <= src_cfg;
      dst_ptr <= dst_pre;
    end else if (adv) begin
      dst_ptr <= dst_ptr + step;
      if (!p2m) src_ptr <= src_ptr + step;
    end
  end

  p_src_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    p2m && !load |=> $stable(src_ptr));
endmodule

// File: rtl/dma_bh_seq.sv
module dma_bh_seq
  import dma_bh_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_pre,
  input  logic [7:0]       burst,
  input  logic [7:0]       hold,
  input  logic             go,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             bus_we,
  output logic             cap,
  output logic             adv,
  output logic             fin
);
  dma_st_e          st;
  logic [CNT_W-1:0] count;
  logic [7:0]       bl, hc, burst_eff;

  assign burst_eff = (burst == 8'd0) ? 8'd1 : burst;
  assign bus_req   = (st == ST_RD) || (st == ST_WR);
  assign bus_we    = (st == ST_WR);
  assign cap       = (st == ST_RD) && bus_gnt;
  assign adv       = (st == ST_WR) && bus_gnt;
  assign fin       = (st == ST_IDLE) && start && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; count <= '0; bl <= '0; hc <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (load) begin
            count <= cnt_pre;
            bl    <= burst_eff;
          end else if (start && (count != '0) && go) begin
            st <= ST_RD;
          end
        end
        ST_RD: if (bus_gnt) st <= ST_WR;
        ST_WR: begin
          if (bus_gnt) begin
            count <= count - CNT_W'(1);
            if (count == CNT_W'(1)) begin
              st <= ST_IDLE;
            end else if (bl == 8'd1) begin
              bl <= burst_eff;
              if (hold == 8'd0) st <= ST_IDLE;
              else begin
                st <= ST_HOLD;
                hc <= hold;
              end
            end else begin
              bl <= bl - 8'd1;
              st <= ST_IDLE;
            end
          end
        end
        default: begin
          if (hc == 8'd1) st <= ST_IDLE;
          else hc <= hc - 8'd1;
        end
      endcase
    end
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> !bus_req);
  p_count_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ($past(load) || $past(bus_req && bus_we && bus_gnt)));
  p_req_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_we));
endmodule

// File: rtl/dma_burst_hold.sv
module dma_burst_hold
  import dma_bh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              periph_rdy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              done
);
  logic [2:0]        mode;
  logic [1:0]        size;
  logic              trig, start, load, fin, cap, adv, go;
  logic [ADDR_W-1:0] src_cfg, dst_pre, src_ptr, dst_ptr;
  logic [CNT_W-1:0]  cnt_pre;
  logic [7:0]        burst, hold;
  logic [31:0]       data_q;

  dma_bh_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fin(fin), .mode(mode), .size(size), .trig(trig),
    .src_cfg(src_cfg), .dst_pre(dst_pre), .cnt_pre(cnt_pre), .burst(burst),
    .hold(hold), .start(start), .done(done), .load(load));

  dma_bh_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .mode(mode),
    .size(size), .src_cfg(src_cfg), .dst_pre(dst_pre),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr));

  dma_bh_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load), .cnt_pre(cnt_pre),
    .burst(burst), .hold(hold), .go(go), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .bus_we(bus_we), .cap(cap), .adv(adv), .fin(fin));

  assign go        = periph_rdy || ((mode == MODE_P2M) && trig);
  assign bus_addr  = bus_we ? dst_ptr : src_ptr;
  assign bus_size  = (mode == MODE_P2M) ? 2'd2 : norm_size(size);
  assign bus_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (cap) data_q <= bus_rdata & lane_mask(size);
  end

  p_beat_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> $stable(bus_addr) && $stable(bus_size) && $stable(bus_wdata));
endmodule

// File: tb/sim_dma_burst_hold.sv
`timescale 1ns/1ps
module sim_dma_burst_hold;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        periph_rdy = 1'b0;
  logic        bus_gnt = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        bus_req, bus_we, done;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int          m_ph = 0;   // 0 idle, 1 read, 2 write, 3 hold
  bit          m_start = 0, m_done = 0, m_trig = 0;
  int          m_mode = 0, m_size = 0, m_burst = 0, m_hold = 0;
  int          m_cnt = 0, m_cpre = 0, m_bl = 0, m_hc = 0;
  logic [31:0] m_src = 0, m_dpre = 0, m_sp = 0, m_dp = 0, m_data = 0;

  dma_burst_hold u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .periph_rdy(periph_rdy), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rdfn(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  function automatic logic [31:0] mask_of(input int sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit er = (m_ph == 1) || (m_ph == 2);
    int es = (m_mode == 1) ? 2 : ((m_size == 3) ? 2 : m_size);
    chk(bus_req == er, "R4 bus_req", {31'd0, bus_req}, {31'd0, er});
    chk(done == m_done, "R8 done", {31'd0, done}, {31'd0, m_done});
    if (er) begin
      chk(bus_we == (m_ph == 2), "R4 bus_we", {31'd0, bus_we}, {31'd0, m_ph == 2});
      chk(bus_addr == ((m_ph == 2) ? m_dp : m_sp), (m_mode == 1) ? "R6 addr" : "R5 addr",
          bus_addr, (m_ph == 2) ? m_dp : m_sp);
      chk(bus_size == es[1:0], (m_mode == 1) ? "R6 size" : "R5 size",
          {30'd0, bus_size}, es);
    end
    if (m_ph == 2) chk(bus_wdata == m_data, "R9 wdata", bus_wdata, m_data);
  endtask

  task automatic model_tick();
    bit go = periph_rdy || (m_mode == 1 && m_trig);
    int be = (m_burst == 0) ? 1 : m_burst;
    bit fin = (m_ph == 0) && m_start && (m_cnt == 0);
    bit was = m_start;
    int stp;
    case (m_ph)
      0: if (m_start && m_cnt != 0 && go) m_ph = 1;
      1: if (bus_gnt) begin
           m_data = rdfn(m_sp) & mask_of(m_size);
           m_ph = 2;
         end
      2: if (bus_gnt) begin
           stp = (m_mode == 1) ? 4 : (m_size == 0) ? 1 : (m_size == 1) ? 2 : 4;
           m_dp = m_dp + stp;
           if (m_mode == 0) m_sp = m_sp + stp;
           m_cnt--;
           if (m_cnt == 0) m_ph = 0;
           else if (m_bl == 1) begin
             m_bl = be;
             if (m_hold == 0) m_ph = 0;
             else begin m_ph = 3; m_hc = m_hold; end
           end else begin
             m_bl--; m_ph = 0;
           end
         end
      default: if (m_hc == 1) m_ph = 0; else m_hc--;
    endcase
    if (fin) begin m_start = 0; m_done = 1; end
    if (cfg_we && !was) begin
      case (cfg_addr)
        3'd0: begin
          m_mode = cfg_wdata[2:0]; m_size = cfg_wdata[5:4]; m_trig = cfg_wdata[9];
          if (cfg_wdata[8] && cfg_wdata[2:0] <= 3'd1) begin
            m_start = 1; m_done = 0; m_dp = m_dpre; m_sp = m_src;
            m_cnt = m_cpre; m_bl = (m_burst == 0) ? 1 : m_burst;
          end
        end
        3'd1: m_src = cfg_wdata;
        3'd2: m_dpre = cfg_wdata;
        3'd3: m_cpre = cfg_wdata[15:0];
        3'd4: begin m_burst = cfg_wdata[7:0]; m_hold = cfg_wdata[15:8]; end
        default: ;
      endcase
    end
  endtask

  // rmode: 0 ready low, 1 ready high, 2 ready pseudo-random
  task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d,
                      input int rmode);
    @(negedge clk);
    compare();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    periph_rdy = (rmode == 1) || (rmode == 2 && lfsr[5]);
    bus_gnt = lfsr[0] | lfsr[3];
    bus_rdata = rdfn(bus_addr);
    model_tick();
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    step(1'b1, a, d, 0);
  endtask

  task automatic run_done(input int rmode, input int lim);
    for (int i = 0; i < lim && !(m_done && m_ph == 0 && !m_start); i++)
      step(1'b0, 3'd0, 32'd0, rmode);
    step(1'b0, 3'd0, 32'd0, rmode);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] dd, input int n,
                       input int b, input int h);
    wreg(3'd1, s); wreg(3'd2, dd); wreg(3'd3, n);
    wreg(3'd4, {16'd0, h[7:0], b[7:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0, "R1 req in reset", {31'd0, bus_req}, 0);
    chk(done == 1'b0, "R1 done in reset", {31'd0, done}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 3'd0, 32'd0, 1); // R1 idle without start

    // R5 R7 R9: 32-bit copy, bursts of 2, hold 3; source rewritten mid-run (R2)
    setup(32'h100, 32'h800, 5, 2, 3);
    wreg(3'd0, 32'h0000_0120);
    for (int i = 0; i < 6; i++) step(1'b0, 3'd0, 32'd0, 1);
    wreg(3'd1, 32'hDEAD_0000);  // R2 ignored while busy
    run_done(1, 400);

    // R5 R7: byte items, burst 0 acts as 1, hold 0
    setup(32'h301, 32'h403, 3, 0, 0);
    wreg(3'd0, 32'h0000_0100);
    run_done(1, 300);

    // R3 R5: halfword items, size 3 later, ready toggling
    setup(32'h502, 32'h602, 6, 3, 2);
    wreg(3'd0, 32'h0000_0110);
    run_done(2, 800);
    setup(32'h700, 32'h900, 3, 1, 1);
    wreg(3'd0, 32'h0000_0130);
    run_done(2, 600);

    // R3 R6: peripheral mode, ready low, software trigger stands in
    setup(32'hA000, 32'hB000, 4, 4, 0);
    wreg(3'd0, 32'h0000_0301);
    run_done(0, 300);

    // R3 R6: peripheral mode, no trigger, ready held low then toggling
    setup(32'hC000, 32'hD000, 4, 2, 5);
    wreg(3'd0, 32'h0000_0111);
    for (int i = 0; i < 10; i++) step(1'b0, 3'd0, 32'd0, 0); // R3 no request without ready
    run_done(2, 800);

    // R8: zero count completes at once
    setup(32'h10, 32'h20, 0, 1, 0);
    wreg(3'd0, 32'h0000_0100);
    step(1'b0, 3'd0, 32'd0, 1);
    @(negedge clk);
    chk(done == 1'b1, "R8 zero count done", {31'd0, done}, 1);
    compare();
    model_tick();

    // R2: unsupported mode start ignored, done kept high
    setup(32'h40, 32'h50, 3, 1, 0);
    wreg(3'd0, 32'h0000_0102);
    for (int i = 0; i < 15; i++) step(1'b0, 3'd0, 32'd0, 1);
    @(negedge clk);
    chk(done == 1'b1 && bus_req == 1'b0, "R2 bad mode ignored", {30'd0, done, bus_req}, 32'h2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R8 actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule